// File: doc/BRIEF.md
# Selectable-Period Fixed Interval Timer

This block produces a steady stream of periodic events from a timebase tick enable. It counts ticks and, after a whole period, raises a one-cycle event, sets a sticky status flag and, when the interrupt enable is set, raises an interrupt request. Afterwards it re-arms at once and keeps running. A 2-bit period code picks one of four power-of-two periods.

The block sits beside a timebase that supplies the tick enable. The register file supplies the period code and the interrupt enable, and it pulses the status clear when software writes the status bit. The period code is sampled while reset is held and again at every event. A new code therefore governs the period that begins at the next event and leaves the running period unchanged. The exponents are parameters. By default the base exponent is 9 and the step is 4, which gives periods of 2^9, 2^13, 2^17 and 2^21 ticks.

Top module: `fit_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the tick count clears, `event_pulse`, `status_flag` and `irq` read 0 after that edge, and the current `period_sel` is captured as the active code.
- R2: Active code c gives a period of 2^(BASE_LOG + STEP_LOG*c) ticks. With the defaults, code 0 gives 2^9, 1 gives 2^13, 2 gives 2^17 and 3 gives 2^21.
- R3: On the clock edge that accepts the last tick of a period, `event_pulse` goes high for exactly one cycle. Counting then restarts from zero with no idle tick, so events repeat without end.
- R4: Only edges with `tick_en` high advance the count. Edges with `tick_en` low neither advance the count nor produce an event.
- R5: `period_sel` is captured into the active code only at an event, so a change during a period takes effect for the period that starts at the next event.
- R6: Every event sets `status_flag`, whatever the value of `irq_en`.
- R7: `status_flag` stays set until an edge with `status_clr` high. If an event lands on the same edge as a clear, the flag stays set.
- R8: `irq` is high exactly when `status_flag` and `irq_en` are both high. Clearing `irq_en` masks the request but does not clear the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timebase tick enable, one tick per high cycle |
| period_sel | input | 2 | Period code, sampled at reset and at each event |
| irq_en | input | 1 | Interrupt enable |
| status_clr | input | 1 | Clears the sticky status flag |
| event_pulse | output | 1 | One-cycle pulse at the end of each period |
| status_flag | output | 1 | Sticky period-expired status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that idle cycles hold the count, that the count never passes the active terminal value, and that each event lasts one cycle and leaves the status set. They also check that a clear drops the flag unless an event collides with it, and that the request follows the status and enable. Only the bench scenarios can show that each code gives the right period length in ticks. The same holds for whether a code change waits for the next event and for whether long random runs with sparse ticks land events on the exact tick that a reference count predicts.

// File: rtl/fit_pkg.sv
// Package: shared widths and types for the fixed interval timer.
// Assumes the period code is two bits wide, giving four periods.
package fit_pkg;
    localparam int SEL_W     = 2;
    localparam int NUM_CODES = 1 << SEL_W;

    typedef logic [SEL_W-1:0] fit_sel_t;

    // Exponent of the period length for a given code.
    function automatic int period_exp(input int code, input int base_log, input int step_log);
        return base_log + step_log * code;
    endfunction
endpackage

// File: rtl/fit_period_decode.sv
// Module: maps the active period code to the terminal count value (period - 1).
// Assumes CNT_W equals the largest period exponent, so every terminal value fits.
module fit_period_decode
    import fit_pkg::*;
#(
    parameter int BASE_LOG = 9,
    parameter int STEP_LOG = 4,
    parameter int CNT_W    = BASE_LOG + STEP_LOG * (NUM_CODES - 1)
) (
    input  fit_sel_t           sel,
    output logic [CNT_W-1:0]   last_val
);
    logic [CNT_W-1:0] table_q [NUM_CODES];

    // Build one terminal value per code: all-ones of width equal to its exponent.
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
        localparam int EXP = period_exp(g, BASE_LOG, STEP_LOG);
        assign table_q[g] = {CNT_W{1'b1}} >> (CNT_W - EXP);
    end

    // Select the terminal value for the active code.
    always_comb begin
        last_val = table_q[sel];
    end
endmodule

// File: rtl/fit_tick_counter.sv
// Module: tick counter that wraps to zero on the tick matching the terminal value.
// Assumes last_val changes only while the count is zero (right after a wrap or reset).
module fit_tick_counter #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] last_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    // Flag the tick that completes the current period.
    always_comb begin
        wrap = tick_en && (cnt == last_val);
    end

    // Advance on ticks and restart from zero at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else if (tick_en) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fit_status_unit.sv
// Module: registers the event pulse, holds the sticky status and forms the request.
// Assumes wrap is a single-cycle qualifier from the counter; a set wins over a clear.
module fit_status_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic status_clr,
    input  logic irq_en,
    output logic event_pulse,
    output logic status_flag,
    output logic irq
);
    // Register the period-end event as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) event_pulse <= 1'b0;
        else        event_pulse <= wrap;
    end

    // Sticky status: set by an event, cleared by software, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)          status_flag <= 1'b0;
        else if (wrap)       status_flag <= 1'b1;
        else if (status_clr) status_flag <= 1'b0;
    end

    // Interrupt request is the status masked by the enable.
    always_comb begin
        irq = status_flag & irq_en;
    end
endmodule

// File: rtl/fit_timer.sv
// Module: top of the selectable-period fixed interval timer.
// Assumes a synchronous active-low reset, one tick per tick_en cycle,
// and that period_sel comes from the control register.
module fit_timer
    import fit_pkg::*;
#(
    parameter int BASE_LOG = 9,
    parameter int STEP_LOG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [SEL_W-1:0] period_sel,
    input  logic             irq_en,
    input  logic             status_clr,
    output logic             event_pulse,
    output logic             status_flag,
    output logic             irq
);
    localparam int CNT_W = BASE_LOG + STEP_LOG * (NUM_CODES - 1);

    fit_sel_t         active_sel;
    logic [CNT_W-1:0] last_val;
    logic [CNT_W-1:0] cnt;
    logic             wrap;

    // Capture the period code at reset and at every event only.
    always_ff @(posedge clk) begin
        if (!rst_n)    active_sel <= period_sel;
        else if (wrap) active_sel <= period_sel;
    end

    fit_period_decode #(
        .BASE_LOG (BASE_LOG),
        .STEP_LOG (STEP_LOG),
        .CNT_W    (CNT_W)
    ) u_decode (
        .sel      (active_sel),
        .last_val (last_val)
    );

    fit_tick_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .last_val (last_val),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    fit_status_unit u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap        (wrap),
        .status_clr  (status_clr),
        .irq_en      (irq_en),
        .event_pulse (event_pulse),
        .status_flag (status_flag),
        .irq         (irq)
    );
endmodule

// File: rtl/fit_timer_checker.sv
// Module: property checker for fit_timer, attached by bind below.
// Assumes it observes the top's ports plus its internal count and terminal value.
module fit_timer_checker #(
    parameter int CNT_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             irq_en,
    input logic             status_clr,
    input logic             event_pulse,
    input logic             status_flag,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] last_val
);
    // R4: an idle cycle leaves the count untouched
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt));

    // R2: the count never passes the active terminal value
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_val);

    // R3: an event lasts exactly one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |=> !event_pulse);

    // R6: an event always leaves the status set
    a_r6_event_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> status_flag);

    // R7: the status holds without a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_flag && !status_clr) |=> status_flag);

    // R7: a clear drops the status unless an event lands on the same edge
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |=> (status_flag == event_pulse));

    // R8: a clear enable masks the request
    a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R8: the request needs the status and appears whenever both are set
    a_r8_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (irq |-> status_flag) and ((irq_en && status_flag) |-> irq));
endmodule

bind fit_timer fit_timer_checker #(.CNT_W(CNT_W)) u_fit_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .irq_en      (irq_en),
    .status_clr  (status_clr),
    .event_pulse (event_pulse),
    .status_flag (status_flag),
    .irq         (irq),
    .cnt         (cnt),
    .last_val    (last_val)
);

// File: tb/tb_fit_timer.sv
module tb_fit_timer;
    localparam int BASE = 3;
    localparam int STEP = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] period_sel = 2'd0;
    logic       irq_en = 1'b0;
    logic       status_clr = 1'b0;
    logic       event_pulse, status_flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state built from the requirements
    int m_cnt = 0;
    int m_act = 0;
    bit m_ev = 1'b0;
    bit m_st = 1'b0;

    fit_timer #(.BASE_LOG(BASE), .STEP_LOG(STEP)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period_sel(period_sel),
        .irq_en(irq_en), .status_clr(status_clr),
        .event_pulse(event_pulse), .status_flag(status_flag), .irq(irq)
    );

    always #4 clk = ~clk;

    function automatic int exp_period(input int code);
        return 1 << (BASE + STEP * code);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive inputs for one edge, update the reference model and compare.
    task automatic step(input bit tk, input bit clr);
        bit wrap;
        @(negedge clk);
        tick_en = tk;
        status_clr = clr;
        @(posedge clk);
        #1;
        wrap = tk && (m_cnt == exp_period(m_act) - 1);
        if (wrap) begin
            m_cnt = 0;
            m_act = period_sel;
        end else if (tk) begin
            m_cnt++;
        end
        m_ev = wrap;
        if (wrap) m_st = 1'b1;
        else if (clr) m_st = 1'b0;
        check("R3 event_pulse", event_pulse, m_ev);
        check("R6/R7 status_flag", status_flag, m_st);
        check("R8 irq", irq, m_st & irq_en);
    endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge clk);
        rst_n = 1'b0;
        period_sel = sel;
        tick_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        m_cnt = 0; m_act = sel; m_ev = 0; m_st = 0;
        check("R1 event_pulse in reset", event_pulse, 0);
        check("R1 status_flag in reset", status_flag, 0);
        check("R1 irq in reset", irq, 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick_en = 1'b0;
    endtask

    // Count ticks from one event to the next with continuous ticks.
    task automatic measure(output int n);
        n = 0;
        do begin
            step(1'b1, 1'b0);
            n++;
        end while (!event_pulse && n < 4000);
    endtask

    initial begin
        int n;
        do_reset(2'd2);
        // R1: the code captured at reset governs the first period
        measure(n);
        check("R1 first period uses code sampled in reset", n, exp_period(2));

        // R2: each code measured after it has been adopted at an event
        for (int c = 0; c < 4; c++) begin
            period_sel = 2'(c);
            measure(n);
            measure(n);
            check($sformatf("R2 period code %0d", c), n, exp_period(c));
        end

        // R3: back-to-back periods without idle ticks
        period_sel = 2'd0;
        measure(n);
        for (int k = 0; k < 3; k++) begin
            measure(n);
            check("R3 continuous re-arm", n, exp_period(0));
        end

        // R4: idle cycles produce no event and do not advance
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
        for (int k = 0; k < 40; k++) step(1'b0, 1'b0);
        measure(n);
        check("R4 idle cycles ignored", n, exp_period(0) - 5);

        // R5: mid-period change waits for the next event
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0);
        period_sel = 2'd1;
        measure(n);
        check("R5 running period keeps old code", n, exp_period(0) - 3);
        measure(n);
        check("R5 new code after event", n, exp_period(1));

        // R6: status sets while masked; R8: enable reveals it
        irq_en = 1'b0;
        step(1'b0, 1'b1);
        period_sel = 2'd0;
        measure(n);
        check("R6 status set with irq masked", status_flag, 1);
        check("R8 irq masked", irq, 0);
        irq_en = 1'b1;
        #1;
        check("R8 irq follows enable", irq, 1);

        // R7: clear colliding with an event keeps the flag set
        for (int k = 0; k < exp_period(0) - 1; k++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        check("R7 set wins over clear", status_flag, 1);
        step(1'b0, 1'b1);
        check("R7 clear alone drops flag", status_flag, 0);

        // Random phase with a fixed seed
        void'($urandom(32'h5eed_f17));
        for (int k = 0; k < 6000; k++) begin
            if ($urandom_range(0, 99) < 2) period_sel = 2'($urandom_range(0, 1));
            if ($urandom_range(0, 99) < 3) irq_en = ~irq_en;
            step($urandom_range(0, 99) < 60, $urandom_range(0, 99) < 5);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule